// File: doc/BRIEF.md
# Bus Interposer Instruction Substitution Controller

This controller is placed in the path between a target processor and its external static RAM. Until a trigger fires, every target access reaches the RAM unchanged. Once the trigger fires, the controller blocks the RAM strobes for the following accesses. It then drives the shared data bus itself, using bytes that a host placed in advance into an instruction queue. Each queue entry can also hand one single access back to the real RAM, or mark the access whose observed port value is the result the host wants.

The host can hold the target in reset at any time. Each reset re-arms the trigger, and the queue contents survive it. The trigger has three modes: a count of bus accesses, a match on the observed 8-bit output port, or a match on a four-address sequence seen on the address bus. On every access the controller records the address and the port value in a capture queue for the host to read back. When substitution is active and the instruction queue runs dry, the target is halted.

Top module: `bus_interposer`

## Requirements
- R1: After reset the RAM strobes are inactive (high), the driver enable is low, halt, overflow, switched and queue-full are low, and the capture queue is empty.
- R2: Before the trigger fires, each access is forwarded. The RAM chip enable is low for the access, the RAM write strobe follows the target write strobe, and the driver enable stays low. The outputs take effect one clock after the access strobe falls.
- R3: After the trigger fires, each access pops one queue entry. If entry bit 8 is clear, the RAM chip enable and write strobe stay high, the driver enable is high, and the driven byte is entry bits 7:0. The driver enable and RAM chip enable are never both active.
- R4: A popped entry with bit 8 set forwards that one access to the RAM, with the driver enable low in the same cycle.
- R5: In count mode (mode 0), the trigger fires on the access whose count since re-arm equals the programmed value N. Accesses 1 to N are forwarded and access N+1 is the first to be substituted.
- R6: In port mode (mode 1), the trigger fires once the observed port equals the programmed byte. The access that shows the match is still forwarded, and the next access is substituted.
- R7: In sequence mode (mode 2), the trigger fires on an access whose address, together with the three accesses before it, equals the four programmed values in order, with slot 0 (bits 16:0) the oldest. The same addresses in another order do not fire it.
- R8: The target reset output follows the host reset request one clock later. A host reset clears the switched state, the access count, the sequence history and the halt, and keeps the instruction queue contents.
- R9: A switched access that finds the instruction queue empty sets a halt. The halt stays until the next host reset. While halted, accesses are neither forwarded, driven, popped nor captured.
- R10: Each non-halted access writes a capture record: address in bits 16:0, port in bits 24:17, and in bit 25 the mark (bit 9) of the entry popped for that access. A read request returns the oldest record with a valid flag one clock later.
- R11: A write to a full capture queue is dropped and sets a sticky overflow flag. The stored records are kept, and a host reset does not clear the flag.
- R12: A host write to a full instruction queue is dropped, and the full flag is shown.
- R13: Mode 3 never fires, so every access is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_tgt_rst | input | 1 | Host request to hold the target in reset |
| tgt_rst | output | 1 | Registered reset to the target |
| ifq_wr | input | 1 | Instruction queue write strobe |
| ifq_wdata | input | DATA_W+2 | Entry: bits 7:0 byte, bit 8 forward-to-RAM, bit 9 mark |
| ifq_full | output | 1 | Instruction queue full |
| trig_mode | input | 2 | 0 count, 1 port, 2 sequence, 3 off |
| trig_count | input | CNT_W | Access count that fires the trigger |
| trig_port | input | DATA_W | Port value that fires the trigger |
| trig_seq | input | 4*ADDR_W | Address sequence, slot 0 oldest |
| cap_rd | input | 1 | Capture queue read request |
| cap_rdata | output | ADDR_W+DATA_W+1 | Capture record |
| cap_rvalid | output | 1 | Record valid, one clock after a read |
| cap_empty | output | 1 | Capture queue empty |
| cap_overflow | output | 1 | Sticky capture overflow |
| tgt_ce_n | input | 1 | Target memory chip enable (access strobe) |
| tgt_we_n | input | 1 | Target memory write strobe |
| tgt_addr | input | ADDR_W | Target address bus |
| tgt_port | input | DATA_W | Observed target output port |
| sram_ce_n | output | 1 | Gated RAM chip enable |
| sram_we_n | output | 1 | Gated RAM write strobe |
| sub_drive_en | output | 1 | Enable for the substitute data driver |
| sub_data | output | DATA_W | Substitute byte |
| tgt_halt | output | 1 | Target halted because the queue ran dry |
| sub_active | output | 1 | Trigger has fired since the last re-arm |

## Verification
The bench builds the block with both queues eight entries deep. This makes a full instruction queue and a capture overflow reachable within a few dozen accesses, while address, port and counter widths stay at their defaults. Count, port and sequence triggers, forwarded and marked entries, halt on an empty queue and re-arm by host reset are each exercised by directed cases. Random rounds then vary trigger counts, entry flags, addresses and port values against a bench model.

// File: rtl/bi_pkg.sv
package bi_pkg;
  typedef enum logic [1:0] {
    TRIG_COUNT = 2'd0,
    TRIG_PORT  = 2'd1,
    TRIG_ADDR  = 2'd2,
    TRIG_OFF   = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/bi_fifo.sv
// Synchronous FIFO with show-ahead head output; DEPTH must be a power of two.
module bi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp;
  logic [AW:0]  rp;
  logic         do_wr;
  logic         do_rd;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign head  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/bi_trigger.sv
// Switch-over detector: access count, port match or address sequence.
module bi_trigger
  import bi_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int SEQ_LEN = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  trig_mode_e                mode,
  input  logic [CNT_W-1:0]          cfg_count,
  input  logic [DATA_W-1:0]         cfg_port,
  input  logic [SEQ_LEN*ADDR_W-1:0] cfg_seq,
  input  logic                      acc_start,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         port,
  output logic                      fired
);
  localparam int HIST = SEQ_LEN - 1;

  logic [ADDR_W-1:0]  hist [HIST];
  logic [HIST-1:0]    hvld;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cnt_inc;
  logic [SEQ_LEN-1:0] slot_ok;
  logic               hit;

  assign cnt_inc = cnt + 1'b1;

  // Slot SEQ_LEN-1 is the current access; lower slots reach back in history.
  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_slot
    if (i == SEQ_LEN - 1) begin : g_now
      assign slot_ok[i] = (addr == cfg_seq[i*ADDR_W +: ADDR_W]);
    end else begin : g_old
      assign slot_ok[i] = hvld[HIST-1-i] &&
                          (hist[HIST-1-i] == cfg_seq[i*ADDR_W +: ADDR_W]);
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_COUNT: hit = acc_start && (cnt_inc == cfg_count);
      TRIG_PORT:  hit = (port == cfg_port);
      TRIG_ADDR:  hit = acc_start && (&slot_ok);
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (acc_start) begin
      hist[0] <= addr;
      for (int j = 1; j < HIST; j++) hist[j] <= hist[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      hvld  <= '0;
      fired <= 1'b0;
    end else begin
      if (acc_start) begin
        cnt     <= cnt_inc;
        hvld[0] <= 1'b1;
        for (int j = 1; j < HIST; j++) hvld[j] <= hvld[j-1];
      end
      if (hit) fired <= 1'b1;
    end
  end
endmodule

// File: rtl/bus_interposer.sv
// Gates RAM strobes, substitutes queued bytes after a trigger, records bus activity.
module bus_interposer
  import bi_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 16,
  parameter int SEQ_LEN   = 4,
  parameter int IFQ_DEPTH = 16,
  parameter int CAP_DEPTH = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            host_tgt_rst,
  output logic                            tgt_rst,
  input  logic                            ifq_wr,
  input  logic [DATA_W+1:0]               ifq_wdata,
  output logic                            ifq_full,
  input  logic [1:0]                      trig_mode,
  input  logic [CNT_W-1:0]                trig_count,
  input  logic [DATA_W-1:0]               trig_port,
  input  logic [SEQ_LEN*ADDR_W-1:0]       trig_seq,
  input  logic                            cap_rd,
  output logic [ADDR_W+DATA_W:0]          cap_rdata,
  output logic                            cap_rvalid,
  output logic                            cap_empty,
  output logic                            cap_overflow,
  input  logic                            tgt_ce_n,
  input  logic                            tgt_we_n,
  input  logic [ADDR_W-1:0]               tgt_addr,
  input  logic [DATA_W-1:0]               tgt_port,
  output logic                            sram_ce_n,
  output logic                            sram_we_n,
  output logic                            sub_drive_en,
  output logic [DATA_W-1:0]               sub_data,
  output logic                            tgt_halt,
  output logic                            sub_active
);
  localparam int IFQ_W    = DATA_W + 2;
  localparam int CAP_W    = ADDR_W + DATA_W + 1;
  localparam int PASS_BIT = DATA_W;
  localparam int MARK_BIT = DATA_W + 1;

  logic              ce_d;
  logic              acc_start;
  logic              live;
  logic              take;
  logic              halting;
  logic              fwd_start;
  logic              sub_start;
  logic              ifq_empty;
  logic [IFQ_W-1:0]  ifq_head;
  logic              cap_full;
  logic [CAP_W-1:0]  cap_head;
  logic [CAP_W-1:0]  cap_wdata;
  logic              cap_pop;
  logic              switched;
  logic              halt_q;
  logic              acc_sub;
  logic              acc_fwd;
  logic              we_n_q;
  logic              tgt_rst_q;
  logic              ovf_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] data_q;
  logic [CAP_W-1:0]  rdata_q;

  // Access start: falling edge of the target chip enable, outside host reset.
  always_ff @(posedge clk) begin
    if (rst) ce_d <= 1'b1;
    else     ce_d <= tgt_ce_n;
  end

  assign acc_start = ce_d && !tgt_ce_n && !host_tgt_rst;
  assign live      = acc_start && !halt_q;
  assign take      = live && switched && !ifq_empty;
  assign halting   = live && switched && ifq_empty;
  assign fwd_start = live && (!switched || (take && ifq_head[PASS_BIT]));
  assign sub_start = take && !ifq_head[PASS_BIT];

  bi_fifo #(.W(IFQ_W), .DEPTH(IFQ_DEPTH)) u_ifq (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ifq_wr),
    .wr_data (ifq_wdata),
    .rd_en   (take),
    .head    (ifq_head),
    .full    (ifq_full),
    .empty   (ifq_empty)
  );

  bi_trigger #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W), .SEQ_LEN (SEQ_LEN)
  ) u_trig (
    .clk       (clk),
    .rst       (rst),
    .clear     (host_tgt_rst),
    .mode      (trig_mode_e'(trig_mode)),
    .cfg_count (trig_count),
    .cfg_port  (trig_port),
    .cfg_seq   (trig_seq),
    .acc_start (acc_start),
    .addr      (tgt_addr),
    .port      (tgt_port),
    .fired     (switched)
  );

  // Per-access decision, held until the chip enable returns high.
  always_ff @(posedge clk) begin
    if (rst || host_tgt_rst) begin
      acc_fwd <= 1'b0;
      acc_sub <= 1'b0;
      we_n_q  <= 1'b1;
      data_q  <= '0;
    end else if (tgt_ce_n) begin
      acc_fwd <= 1'b0;
      acc_sub <= 1'b0;
      we_n_q  <= 1'b1;
    end else if (acc_start) begin
      acc_fwd <= fwd_start;
      acc_sub <= sub_start;
      we_n_q  <= !fwd_start || tgt_we_n;
      if (sub_start) data_q <= ifq_head[DATA_W-1:0];
    end else begin
      we_n_q  <= !acc_fwd || tgt_we_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || host_tgt_rst) halt_q <= 1'b0;
    else if (halting)        halt_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    tgt_rst_q <= rst || host_tgt_rst;
  end

  // Capture path: one record per live access, dropped with a sticky flag when full.
  assign cap_wdata = {take && ifq_head[MARK_BIT], tgt_port, tgt_addr};
  assign cap_pop   = cap_rd && !cap_empty;

  bi_fifo #(.W(CAP_W), .DEPTH(CAP_DEPTH)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (live),
    .wr_data (cap_wdata),
    .rd_en   (cap_pop),
    .head    (cap_head),
    .full    (cap_full),
    .empty   (cap_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (live && cap_full) ovf_q <= 1'b1;
      rvalid_q <= cap_pop;
      if (cap_pop) rdata_q <= cap_head;
    end
  end

  assign tgt_rst      = tgt_rst_q;
  assign sram_ce_n    = !acc_fwd;
  assign sram_we_n    = we_n_q;
  assign sub_drive_en = acc_sub;
  assign sub_data     = data_q;
  assign tgt_halt     = halt_q;
  assign sub_active   = switched;
  assign cap_overflow = ovf_q;
  assign cap_rvalid   = rvalid_q;
  assign cap_rdata    = rdata_q;
endmodule

// File: rtl/bi_checker.sv
module bi_checker (
  input logic clk,
  input logic rst,
  input logic host_tgt_rst,
  input logic tgt_rst,
  input logic tgt_ce_n,
  input logic cap_rd,
  input logic cap_empty,
  input logic cap_rvalid,
  input logic cap_overflow,
  input logic sram_ce_n,
  input logic sub_drive_en,
  input logic tgt_halt,
  input logic sub_active
);
  assert_one_driver_R3: assert property (@(posedge clk) disable iff (rst)
    !(sub_drive_en && !sram_ce_n));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_ce_n) |=> (sram_ce_n && !sub_drive_en));

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tgt_halt && !host_tgt_rst) |=> tgt_halt);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    tgt_halt |-> (sram_ce_n && !sub_drive_en));

  assert_rst_on_R8: assert property (@(posedge clk) disable iff (rst)
    host_tgt_rst |=> tgt_rst);

  assert_rst_off_R8: assert property (@(posedge clk) disable iff (rst)
    !host_tgt_rst |=> !tgt_rst);

  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    host_tgt_rst |=> !sub_active);

  assert_switch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sub_active && !host_tgt_rst) |=> sub_active);

  assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (rst)
    cap_overflow |=> cap_overflow);

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    cap_rvalid |-> $past(cap_rd && !cap_empty));
endmodule

bind bus_interposer bi_checker u_bi_checker (
  .clk          (clk),
  .rst          (rst),
  .host_tgt_rst (host_tgt_rst),
  .tgt_rst      (tgt_rst),
  .tgt_ce_n     (tgt_ce_n),
  .cap_rd       (cap_rd),
  .cap_empty    (cap_empty),
  .cap_rvalid   (cap_rvalid),
  .cap_overflow (cap_overflow),
  .sram_ce_n    (sram_ce_n),
  .sub_drive_en (sub_drive_en),
  .tgt_halt     (tgt_halt),
  .sub_active   (sub_active)
);

// File: tb/bus_interposer_bench.sv
`timescale 1ns/1ps
module bus_interposer_bench;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int IFQ_D = 8;
  localparam int CAP_D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_tgt_rst = 1'b0;
  logic tgt_rst;
  logic ifq_wr = 1'b0;
  logic [DW+1:0] ifq_wdata = '0;
  logic ifq_full;
  logic [1:0] trig_mode = 2'd3;
  logic [15:0] trig_count = '0;
  logic [DW-1:0] trig_port = 8'h5A;
  logic [4*AW-1:0] trig_seq = '0;
  logic cap_rd = 1'b0;
  logic [AW+DW:0] cap_rdata;
  logic cap_rvalid, cap_empty, cap_overflow;
  logic tgt_ce_n = 1'b1;
  logic tgt_we_n = 1'b1;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] tgt_port = '0;
  logic sram_ce_n, sram_we_n, sub_drive_en, tgt_halt, sub_active;
  logic [DW-1:0] sub_data;

  always #4 clk = ~clk;

  bus_interposer #(.IFQ_DEPTH(IFQ_D), .CAP_DEPTH(CAP_D)) u_bus_interposer (
    .clk(clk), .rst(rst), .host_tgt_rst(host_tgt_rst), .tgt_rst(tgt_rst),
    .ifq_wr(ifq_wr), .ifq_wdata(ifq_wdata), .ifq_full(ifq_full),
    .trig_mode(trig_mode), .trig_count(trig_count), .trig_port(trig_port),
    .trig_seq(trig_seq), .cap_rd(cap_rd), .cap_rdata(cap_rdata),
    .cap_rvalid(cap_rvalid), .cap_empty(cap_empty), .cap_overflow(cap_overflow),
    .tgt_ce_n(tgt_ce_n), .tgt_we_n(tgt_we_n), .tgt_addr(tgt_addr),
    .tgt_port(tgt_port), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sub_drive_en(sub_drive_en), .sub_data(sub_data), .tgt_halt(tgt_halt),
    .sub_active(sub_active)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Bench model state
  bit m_sw, m_halt, m_ovf;
  int m_cnt, m_hn;
  logic [AW-1:0] m_h [3];
  logic [DW+1:0] mq [$];
  logic [AW+DW:0] mc [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R5 count trigger";
      2'd1: return "R6 port trigger";
      2'd2: return "R7 sequence trigger";
      default: return "R13 trigger off";
    endcase
  endfunction

  function automatic logic [AW-1:0] seq_slot(input int i);
    return trig_seq[i*AW +: AW];
  endfunction

  task automatic host_reset();
    @(negedge clk);
    host_tgt_rst = 1'b1;
    tgt_port = '0;
    @(negedge clk);
    chk("R8 target reset asserted", 32'(tgt_rst), 32'd1);
    host_tgt_rst = 1'b0;
    m_sw = 0; m_halt = 0; m_cnt = 0; m_hn = 0;
    @(negedge clk);
    chk("R8 target reset released", 32'(tgt_rst), 32'd0);
    chk("R8 halt cleared", 32'(tgt_halt), 32'd0);
    chk("R8 trigger re-armed", 32'(sub_active), 32'd0);
  endtask

  task automatic load(input logic [DW+1:0] e);
    @(negedge clk);
    ifq_wr = 1'b1;
    ifq_wdata = e;
    @(negedge clk);
    ifq_wr = 1'b0;
    if (mq.size() < IFQ_D) mq.push_back(e);
  endtask

  task automatic access(input logic [AW-1:0] a, input logic we, input logic [DW-1:0] p);
    bit fwd = 0, sub = 0, fire = 0, live;
    logic [DW-1:0] b = '0;
    logic mk = 1'b0;
    logic [DW+1:0] e;
    string tag;
    live = !m_halt;
    tag = "R2 forward before trigger";
    if (live) begin
      if (!m_sw) fwd = 1;
      else if (mq.size() == 0) begin m_halt = 1; tag = "R9 halt on empty"; end
      else begin
        e = mq.pop_front();
        mk = e[DW+1];
        if (e[DW]) begin fwd = 1; tag = "R4 pass-through entry"; end
        else begin sub = 1; b = e[DW-1:0]; tag = "R3 substitute"; end
      end
      if (mc.size() < CAP_D) mc.push_back({mk, p, a});
      else m_ovf = 1;
    end else tag = "R9 halted access ignored";
    m_cnt = (m_cnt + 1) & 32'hffff;
    if (trig_mode == 2'd0 && m_cnt == int'(trig_count)) fire = 1;
    if (trig_mode == 2'd2 && m_hn >= 3 && m_h[2] == seq_slot(0) &&
        m_h[1] == seq_slot(1) && m_h[0] == seq_slot(2) && a == seq_slot(3)) fire = 1;
    m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = a;
    if (m_hn < 3) m_hn++;
    if (trig_mode == 2'd1 && p == trig_port) fire = 1;

    @(negedge clk);
    tgt_ce_n = 1'b0; tgt_we_n = we; tgt_addr = a; tgt_port = p;
    @(negedge clk);
    chk({tag, " ram ce"}, 32'(sram_ce_n), 32'(!fwd));
    chk({tag, " ram we"}, 32'(sram_we_n), fwd ? 32'(we) : 32'd1);
    chk({tag, " drive en"}, 32'(sub_drive_en), 32'(sub));
    if (sub) chk({tag, " byte"}, 32'(sub_data), 32'(b));
    chk({tag, " halt"}, 32'(tgt_halt), 32'(m_halt));
    if (fire) m_sw = 1;
    @(negedge clk);
    tgt_ce_n = 1'b1;
    @(negedge clk);
    chk("R2 idle ram ce", 32'(sram_ce_n), 32'd1);
    chk("R3 idle drive en", 32'(sub_drive_en), 32'd0);
    chk(mode_tag(trig_mode), 32'(sub_active), 32'(m_sw));
  endtask

  task automatic drain();
    logic [AW+DW:0] exp;
    while (mc.size() > 0) begin
      exp = mc.pop_front();
      @(negedge clk);
      cap_rd = 1'b1;
      @(negedge clk);
      cap_rd = 1'b0;
      chk("R10 capture valid", 32'(cap_rvalid), 32'd1);
      chk("R10 capture record", 32'(cap_rdata), 32'(exp));
    end
    @(negedge clk);
    chk("R10 capture empty", 32'(cap_empty), 32'd1);
  endtask

  function automatic logic [AW-1:0] raddr();
    return AW'($urandom & 32'h1ffff);
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd715);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ram ce", 32'(sram_ce_n), 32'd1);
    chk("R1 ram we", 32'(sram_we_n), 32'd1);
    chk("R1 drive en", 32'(sub_drive_en), 32'd0);
    chk("R1 halt", 32'(tgt_halt), 32'd0);
    chk("R1 overflow", 32'(cap_overflow), 32'd0);
    chk("R1 cap empty", 32'(cap_empty), 32'd1);
    chk("R1 ifq full", 32'(ifq_full), 32'd0);
    chk("R1 switched", 32'(sub_active), 32'd0);

    // Count trigger with plain, forwarded and marked entries; queue loaded before re-arm (R8)
    trig_mode = 2'd0; trig_count = 16'd3;
    load({2'b00, 8'hA7});
    load({2'b01, 8'h00});
    load({2'b10, 8'h3C});
    host_reset();
    access(17'h00100, 1'b1, 8'h01);
    access(17'h00101, 1'b0, 8'h02);
    access(17'h00102, 1'b1, 8'h03);
    access(17'h00200, 1'b1, 8'h04);
    access(17'h00201, 1'b0, 8'h05);
    access(17'h00202, 1'b1, 8'h06);
    access(17'h00203, 1'b1, 8'h07);
    access(17'h00204, 1'b1, 8'h08);
    drain();

    // Sequence trigger: wrong order then right order (R7)
    trig_mode = 2'd2;
    trig_seq = {17'h1F00D, 17'h0C0DE, 17'h00B0B, 17'h0ABCD};
    load({2'b00, 8'h11});
    load({2'b00, 8'h22});
    host_reset();
    access(17'h1F00D, 1'b1, 8'h10);
    access(17'h0C0DE, 1'b1, 8'h11);
    access(17'h00B0B, 1'b1, 8'h12);
    access(17'h0ABCD, 1'b1, 8'h13);
    drain();
    access(17'h0ABCD, 1'b1, 8'h14);
    access(17'h00B0B, 1'b1, 8'h15);
    access(17'h0C0DE, 1'b1, 8'h16);
    access(17'h1F00D, 1'b1, 8'h17);
    access(17'h00010, 1'b1, 8'h18);
    access(17'h00011, 1'b1, 8'h19);
    access(17'h00012, 1'b1, 8'h1A);
    drain();

    // Port trigger (R6)
    trig_mode = 2'd1; trig_port = 8'h5A;
    load({2'b00, 8'hC3});
    host_reset();
    access(17'h00300, 1'b1, 8'h11);
    access(17'h00301, 1'b1, 8'h5A);
    access(17'h00302, 1'b1, 8'h22);
    access(17'h00303, 1'b1, 8'h23);
    drain();

    // Trigger off and capture overflow (R13, R11)
    trig_mode = 2'd3;
    host_reset();
    for (int i = 0; i < 10; i++) access(raddr(), 1'($urandom), 8'($urandom));
    chk("R11 overflow set", 32'(cap_overflow), 32'(m_ovf));
    drain();
    chk("R11 overflow sticky after drain", 32'(cap_overflow), 32'd1);
    host_reset();
    chk("R11 overflow survives host reset", 32'(cap_overflow), 32'd1);

    // Instruction queue full (R12)
    for (int i = 0; i < IFQ_D + 1; i++) load({2'b00, 8'(i * 17 + 5)});
    chk("R12 ifq full flag", 32'(ifq_full), 32'd1);
    trig_mode = 2'd0; trig_count = 16'd1;
    host_reset();
    for (int i = 0; i < IFQ_D + 2; i++) access(raddr(), 1'b1, 8'($urandom));
    chk("R12 dropped entry not used", 32'(tgt_halt), 32'd1);
    drain();

    // Constrained random rounds
    for (int r = 0; r < 20; r++) begin
      int n_ent;
      trig_mode = 2'd0;
      trig_count = 16'($urandom_range(1, 4));
      n_ent = $urandom_range(1, 3);
      for (int k = 0; k < n_ent; k++) load(10'($urandom));
      host_reset();
      for (int k = 0; k < int'(trig_count) + n_ent + 1; k++)
        access(raddr(), 1'($urandom), 8'($urandom));
      drain();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule